// File: doc/BRIEF.md
# Flow-Control XOFF Request Scheduler

This block sits beside a transmit MAC and decides when a link-pause (PAUSE) or per-priority (PFC) XOFF frame must go out. Each frame type has two request sources: a level from the client and a bit or field from software. The two are OR-ed into one combined level per type. A rising edge of a combined level schedules one XOFF frame. The block holds that request until the frame currently on the wire has finished. It then presents a send command to the frame generator. The command carries the frame type and the per-queue XOFF enable vector.

Retransmission mode can be turned on. In that mode a combined level that stays high causes the XOFF of that type to be sent again each time a hold-off interval expires. The interval is given in pause quanta. An internal tick marks each quantum, and the tick period in clocks is a parameter. PAUSE and PFC each have their own hold-off timer. A timer restarts whenever the frame generator accepts a command of its type.

The send command uses a valid/ready interface. Once `cmd_valid` is high, the block holds it high, with `cmd_is_pfc` and `cmd_prio` unchanged, until a cycle in which `cmd_ready` is also high. That cycle is the hand-off. A new command is raised only while `frame_busy` is low and no command is waiting.

Top module: `xoff_sched`

## Requirements
- R1: A rising edge of the combined pause level (`cli_pause | sw_pause`) produces one command with `cmd_is_pfc`=0 and `cmd_prio`=0. With `retx_en`=0, exactly one command is produced per rising edge, however long the level stays high.
- R2: `cmd_valid` does not rise while `frame_busy` is high. A request made during a busy frame is issued within 3 cycles after `frame_busy` falls.
- R3: The PFC request is the bitwise OR of `cli_pfc` and `sw_pfc`, with bit i standing for queue i. A rising edge of its OR-reduction produces one command with `cmd_is_pfc`=1. That command's `cmd_prio` equals the combined vector at the trigger, so 8'h03 selects queues 0 and 1.
- R4: `sw_pause` alone triggers a PAUSE XOFF exactly as `cli_pause` does.
- R5: With `retx_en`=1, the hold-off H (`holdoff_q`, in quanta) and CLKS_PER_Q clocks per quantum, a combined level held high is resent. Under an always-ready generator, the gap between consecutive accepted commands of that type lies in [(H-1)*CLKS_PER_Q+4, H*CLKS_PER_Q+3] cycles.
- R6: The PAUSE and PFC hold-off timers are independent. Both types held high each retransmit on their own schedule. A PFC gap may stretch by up to 2 further cycles when a PAUSE is issued first.
- R7: While the combined level of a type stays high in retransmission mode, asserting or releasing the other source of that type causes no extra command. Only hold-off expiry resends.
- R8: When PAUSE and PFC are both pending at issue time, the PAUSE command is issued first and the PFC command follows.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_is_pfc` and `cmd_prio` stay unchanged in the next cycle.
- R10: Synchronous active-high `rst` clears `cmd_valid`, all pending requests and the timers. A request pending before reset is not issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cli_pause | input | 1 | Client link-pause request level |
| cli_pfc | input | NQ | Client per-priority request vector |
| sw_pause | input | 1 | Software link-pause request bit |
| sw_pfc | input | NQ | Software per-priority request field |
| retx_en | input | 1 | Retransmission mode enable |
| holdoff_q | input | QW | Hold-off interval in pause quanta |
| frame_busy | input | 1 | High while a frame is being transmitted |
| cmd_valid | output | 1 | Send command valid |
| cmd_ready | input | 1 | Frame generator accepts the command |
| cmd_is_pfc | output | 1 | 0 = PAUSE frame, 1 = PFC frame |
| cmd_prio | output | NQ | Per-queue XOFF enables (zero for PAUSE) |

## Verification
Every nonzero PFC vector is driven, with its low half taken from the client port and its high half from software. A wrong merge or a wrong latched vector therefore shows up as a `cmd_prio` mismatch, and each queue bit is checked on its own. Long steady pause levels are applied with retransmission off and then on, for hold-off values 1 to 6. Counting accepted commands and measuring the gap between them separates one-per-edge behaviour from timer-driven resends, and shows whether the timer is off by a quantum. Other patterns are each aimed at one rule: requests that arrive during a busy frame, simultaneous PAUSE and PFC with the generator stalled, a second source switched on under a held level, and a reset with a request pending. These test gating, priority, back-pressure and clearing.

// File: rtl/xoff_pkg.sv
package xoff_pkg;
  typedef enum logic {
    XT_PAUSE = 1'b0,
    XT_PFC   = 1'b1
  } xtype_e;
  localparam int NTYPE = 2;
endpackage

// File: rtl/xoff_qtick.sv
module xoff_qtick #(
  parameter int CLKS_PER_Q = 4
) (
  input  logic clk,
  input  logic rst,
  output logic qtick
);
  localparam int CW = (CLKS_PER_Q > 1) ? $clog2(CLKS_PER_Q) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_Q - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qtick = (cnt == LAST);
endmodule

// File: rtl/xoff_holdoff_timer.sv
module xoff_holdoff_timer #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          qtick,
  input  logic [QW-1:0] holdoff_q,
  output logic          expired
);
  logic [QW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
    end else if (qtick && (elapsed != {QW{1'b1}})) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expired = (elapsed >= holdoff_q);
endmodule

// File: rtl/xoff_req_track.sv
module xoff_req_track #(
  parameter int NQ = 8,
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  logic [NQ-1:0] vec,
  input  logic          retx_en,
  input  logic [QW-1:0] holdoff_q,
  input  logic          qtick,
  input  logic          take,
  input  logic          accept,
  output logic          pend,
  output logic [NQ-1:0] pend_vec
);
  logic prev_lvl;
  logic inflight;
  logic expired;
  logic rise;
  logic resend;
  logic trigger;

  xoff_holdoff_timer #(.QW(QW)) tmr_i (
    .clk       (clk),
    .rst       (rst),
    .restart   (accept),
    .qtick     (qtick),
    .holdoff_q (holdoff_q),
    .expired   (expired)
  );

  assign rise    = lvl & ~prev_lvl;
  assign resend  = retx_en & lvl & expired & ~pend & ~inflight;
  assign trigger = rise | resend;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      pend     <= 1'b0;
      pend_vec <= '0;
      inflight <= 1'b0;
    end else begin
      prev_lvl <= lvl;
      if (take) begin
        pend     <= 1'b0;
        inflight <= 1'b1;
      end
      if (accept) begin
        inflight <= 1'b0;
      end
      if (trigger) begin
        pend     <= 1'b1;
        pend_vec <= vec;
      end
    end
  end
endmodule

// File: rtl/xoff_sched.sv
module xoff_sched
  import xoff_pkg::*;
#(
  parameter int NQ         = 8,
  parameter int QW         = 8,
  parameter int CLKS_PER_Q = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cli_pause,
  input  logic [NQ-1:0] cli_pfc,
  input  logic          sw_pause,
  input  logic [NQ-1:0] sw_pfc,
  input  logic          retx_en,
  input  logic [QW-1:0] holdoff_q,
  input  logic          frame_busy,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_is_pfc,
  output logic [NQ-1:0] cmd_prio
);
  logic                   qtick;
  logic [NTYPE-1:0]       lvl;
  logic [NQ-1:0]          vec    [NTYPE];
  logic [NTYPE-1:0]       pend;
  logic [NQ-1:0]          pvec   [NTYPE];
  logic [NTYPE-1:0]       take;
  logic [NTYPE-1:0]       accept;
  logic                   load;
  logic [NQ-1:0]          pfc_all;

  xoff_qtick #(.CLKS_PER_Q(CLKS_PER_Q)) qt_i (
    .clk   (clk),
    .rst   (rst),
    .qtick (qtick)
  );

  assign pfc_all       = cli_pfc | sw_pfc;
  assign lvl[XT_PAUSE] = cli_pause | sw_pause;
  assign vec[XT_PAUSE] = '0;
  assign lvl[XT_PFC]   = |pfc_all;
  assign vec[XT_PFC]   = pfc_all;

  // PAUSE has priority over PFC at issue time
  assign load           = ~cmd_valid & ~frame_busy & (|pend);
  assign take[XT_PAUSE] = load & pend[XT_PAUSE];
  assign take[XT_PFC]   = load & ~pend[XT_PAUSE] & pend[XT_PFC];

  for (genvar t = 0; t < NTYPE; t++) begin : g_type
    assign accept[t] = cmd_valid & cmd_ready & (cmd_is_pfc == (t == int'(XT_PFC)));
    xoff_req_track #(.NQ(NQ), .QW(QW)) trk_i (
      .clk       (clk),
      .rst       (rst),
      .lvl       (lvl[t]),
      .vec       (vec[t]),
      .retx_en   (retx_en),
      .holdoff_q (holdoff_q),
      .qtick     (qtick),
      .take      (take[t]),
      .accept    (accept[t]),
      .pend      (pend[t]),
      .pend_vec  (pvec[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid  <= 1'b0;
      cmd_is_pfc <= 1'b0;
      cmd_prio   <= '0;
    end else if (load) begin
      cmd_valid  <= 1'b1;
      cmd_is_pfc <= ~pend[XT_PAUSE];
      cmd_prio   <= pend[XT_PAUSE] ? '0 : pvec[XT_PFC];
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/xoff_sched_chk.sv
module xoff_sched_chk #(
  parameter int NQ = 8,
  parameter int QW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_busy,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_is_pfc,
  input logic [NQ-1:0] cmd_prio,
  input logic [QW-1:0] holdoff_q,
  input logic          retx_en
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_is_pfc) && $stable(cmd_prio));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> !$past(frame_busy));

  // R1
  pause_noprio_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_is_pfc |-> cmd_prio == '0);

  // R3
  pfc_someq_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_is_pfc |-> cmd_prio != '0);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !cmd_valid);
endmodule

bind xoff_sched xoff_sched_chk #(.NQ(NQ), .QW(QW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .frame_busy (frame_busy),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_is_pfc (cmd_is_pfc),
  .cmd_prio   (cmd_prio),
  .holdoff_q  (holdoff_q),
  .retx_en    (retx_en)
);

// File: tb/xoff_sched_tb_top.sv
module xoff_sched_tb_top;
  localparam int CLK_P = 10;
  localparam int NQ    = 8;
  localparam int QW    = 8;
  localparam int CQ    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cli_pause = 1'b0;
  logic [NQ-1:0] cli_pfc = '0;
  logic          sw_pause = 1'b0;
  logic [NQ-1:0] sw_pfc = '0;
  logic          retx_en = 1'b0;
  logic [QW-1:0] holdoff_q = '0;
  logic          frame_busy = 1'b0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b1;
  logic          cmd_is_pfc;
  logic [NQ-1:0] cmd_prio;

  int checks = 0;
  int errors = 0;

  xoff_sched #(.NQ(NQ), .QW(QW), .CLKS_PER_Q(CQ)) dut_i (
    .clk(clk), .rst(rst), .cli_pause(cli_pause), .cli_pfc(cli_pfc),
    .sw_pause(sw_pause), .sw_pfc(sw_pfc), .retx_en(retx_en),
    .holdoff_q(holdoff_q), .frame_busy(frame_busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_is_pfc(cmd_is_pfc), .cmd_prio(cmd_prio)
  );

  always #(CLK_P/2) clk = ~clk;

  // accept monitor
  int          cyc = 0;
  int          n_acc [2];
  int          last_t [2];
  int          min_gap [2];
  int          max_gap [2];
  logic [NQ-1:0] last_prio;
  int          first_type;

  task automatic clr_stats();
    for (int t = 0; t < 2; t++) begin
      n_acc[t] = 0; last_t[t] = -1; min_gap[t] = 1000000; max_gap[t] = 0;
    end
    first_type = -1;
    last_prio = '0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && cmd_valid && cmd_ready) begin
      automatic int t = cmd_is_pfc ? 1 : 0;
      if (first_type < 0) first_type = t;
      if (last_t[t] >= 0) begin
        if (cyc - last_t[t] < min_gap[t]) min_gap[t] = cyc - last_t[t];
        if (cyc - last_t[t] > max_gap[t]) max_gap[t] = cyc - last_t[t];
      end
      last_t[t] = cyc;
      n_acc[t] = n_acc[t] + 1;
      last_prio = cmd_prio;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_stats();
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R10: reset state
    chk(cmd_valid == 1'b0, "R10 reset valid", int'(cmd_valid), 0);

    // R1: one frame per rise, retransmission off
    clr_stats();
    cli_pause = 1'b1; wait_n(200);
    chk(n_acc[0] == 1, "R1 single pause", n_acc[0], 1);
    chk(last_prio == '0, "R1 pause prio", int'(last_prio), 0);
    cli_pause = 1'b0; wait_n(3); cli_pause = 1'b1; wait_n(50); cli_pause = 1'b0; wait_n(5);
    chk(n_acc[0] == 2, "R1 second rise", n_acc[0], 2);
    chk(n_acc[1] == 0, "R1 no pfc", n_acc[1], 0);

    // R4: software pause bit
    clr_stats();
    sw_pause = 1'b1; wait_n(60); sw_pause = 1'b0; wait_n(5);
    chk(n_acc[0] == 1, "R4 sw pause", n_acc[0], 1);

    // R2: gated by busy frame
    clr_stats();
    frame_busy = 1'b1; cli_pause = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin wait_n(1); if (cmd_valid) seen++; end
      chk(seen == 0, "R2 held while busy", seen, 0);
    end
    frame_busy = 1'b0; wait_n(3);
    chk(n_acc[0] == 1, "R2 issued after busy", n_acc[0], 1);
    cli_pause = 1'b0; wait_n(5);

    // R3: every nonzero vector, split across sources
    begin
      int bad = 0;
      for (int v = 1; v < 256; v++) begin
        clr_stats();
        cli_pfc = NQ'(v) & 8'h0F; sw_pfc = NQ'(v) & 8'hF0;
        wait_n(8);
        if (n_acc[1] != 1 || last_prio != NQ'(v)) begin
          bad++;
          if (bad == 1) chk(1'b0, "R3 pfc vector", int'(last_prio), v);
        end
        cli_pfc = '0; sw_pfc = '0; wait_n(3);
      end
      chk(bad == 0, "R3 pfc sweep", bad, 0);
    end
    clr_stats();
    cli_pfc = 8'h03; wait_n(8);
    chk(last_prio == 8'h03 && n_acc[1] == 1, "R3 queues 0 and 1", int'(last_prio), 3);
    cli_pfc = '0; wait_n(3);

    // R9: back-pressure hold
    clr_stats();
    cmd_ready = 1'b0; cli_pfc = 8'h5A; wait_n(4);
    begin
      int moved = 0;
      for (int i = 0; i < 10; i++) begin
        wait_n(1);
        if (!cmd_valid || !cmd_is_pfc || cmd_prio != 8'h5A) moved++;
      end
      chk(moved == 0, "R9 stable under stall", moved, 0);
    end
    cmd_ready = 1'b1; wait_n(2);
    chk(n_acc[1] == 1 && last_prio == 8'h5A, "R9 accepted once", n_acc[1], 1);
    cli_pfc = '0; wait_n(3);

    // R8: PAUSE wins
    clr_stats();
    frame_busy = 1'b1; cmd_ready = 1'b0;
    cli_pause = 1'b1; cli_pfc = 8'h80; wait_n(4);
    frame_busy = 1'b0; wait_n(3);
    chk(cmd_valid && !cmd_is_pfc, "R8 pause first", int'(cmd_is_pfc), 0);
    cmd_ready = 1'b1; wait_n(6);
    chk(first_type == 0, "R8 first accepted", first_type, 0);
    chk(n_acc[1] == 1, "R8 pfc follows", n_acc[1], 1);
    cli_pause = 1'b0; cli_pfc = '0; wait_n(5);

    // R5: retransmission sweep over hold-off
    retx_en = 1'b1;
    for (int h = 1; h <= 6; h++) begin
      holdoff_q = QW'(h);
      clr_stats();
      cli_pause = 1'b1; wait_n(8 * h * CQ + 20);
      cli_pause = 1'b0; wait_n(h * CQ + 10);
      chk(n_acc[0] >= 3, "R5 resend count", n_acc[0], 3);
      chk(min_gap[0] >= (h - 1) * CQ + 4, "R5 min gap", min_gap[0], (h - 1) * CQ + 4);
      chk(max_gap[0] <= h * CQ + 3, "R5 max gap", max_gap[0], h * CQ + 3);
    end

    // R7: second source under held level
    holdoff_q = QW'(5);
    clr_stats();
    cli_pause = 1'b1; wait_n(7);
    sw_pause = 1'b1; wait_n(30);
    cli_pause = 1'b0; wait_n(40);
    sw_pause = 1'b0; wait_n(30);
    chk(min_gap[0] >= 20, "R7 no extra frame", min_gap[0], 20);
    chk(max_gap[0] <= 23, "R7 timer only", max_gap[0], 23);

    // R6: independent timers
    holdoff_q = QW'(4);
    clr_stats();
    cli_pause = 1'b1; wait_n(9);
    sw_pfc = 8'h21; wait_n(150);
    cli_pause = 1'b0; sw_pfc = '0; wait_n(30);
    chk(n_acc[0] >= 4 && n_acc[1] >= 4, "R6 both resend", n_acc[1], 4);
    chk(min_gap[0] >= 16 && max_gap[0] <= 19, "R6 pause gap", max_gap[0], 19);
    chk(min_gap[1] >= 16 && max_gap[1] <= 21, "R6 pfc gap", max_gap[1], 21);
    retx_en = 1'b0;

    // R10: reset drops a pending request
    clr_stats();
    frame_busy = 1'b1; cli_pause = 1'b1; wait_n(4);
    rst = 1'b1; cli_pause = 1'b0; wait_n(2);
    rst = 1'b0; frame_busy = 1'b0; wait_n(12);
    chk(n_acc[0] == 0, "R10 pending cleared", n_acc[0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule